// File: doc/BRIEF.md
# Serial Memory Slave Read Engine

This block is the slave side of a two-wire serial bus in front of a byte-wide memory array. It watches an oversampled clock line and data line, finds start and stop conditions, and decodes the device-select byte. That byte carries a fixed four-bit device code and a direction bit in its last position. A write-direction transaction carries a two-byte word address, high byte first, and that address is loaded into an internal 14-bit counter. A read-direction transaction returns bytes from the memory, starting at the counter.

Three read forms come out of this. A current-address read continues from wherever the counter points. A random read is an address-only write followed by a repeated start and a read. A sequential read keeps going for as long as the bus master acknowledges each byte. The counter always holds one past the last byte fetched and survives between transactions. It wraps from the top of the array to zero. The data line is only ever pulled low. Each byte is fetched from the memory through a request channel with valid/ready handshaking. The response is a plain valid strobe with data.

The request channel follows these rules. Once `mem_req_valid` is raised, it stays high and `mem_req_addr` stays fixed until a cycle in which `mem_req_ready` is high. At most one request is outstanding. The response must arrive within half a bus clock period of acceptance, and it is taken whenever `mem_rsp_valid` is high. The response side has no back-pressure.

Top module: `serial_mem_rd_slave`

## Requirements
- R1: After reset the data line is released (`sda_drive_low` = 0), no memory request is pending, and the word counter is zero, so a current-address read returns the byte at address 0.
- R2: The block acknowledges a device-select byte (pulls SDA low during the ninth clock) only when its upper four bits are 1010. Bits 3..1 are ignored. With any other code it neither acknowledges nor drives SDA until the next start condition.
- R3: A write-direction device-select byte (bit 0 = 0) followed by two acknowledged address bytes loads the counter with {high[5:0], low}. The top two bits of the high byte are ignored. A third written byte is not acknowledged.
- R4: A read-direction device-select byte (bit 0 = 1) is acknowledged. It is followed by the byte at the counter, shifted out most significant bit first, one bit per bus clock. The counter then holds that address plus one.
- R5: A repeated start keeps the loaded address, so a random read returns the byte at the written address.
- R6: When the master acknowledges (SDA low) on the ninth clock after a data byte, the next byte follows. The address wraps from 16383 to 0.
- R7: When the master leaves SDA high on the ninth clock, the block releases SDA and drives it no more until the next start condition.
- R8: A stop condition in any state returns the block to idle with SDA released. A start condition restarts device-select decoding. An address write cut off by a stop after the high byte leaves the counter unchanged.
- R9: `sda_drive_low` changes only in the cycle after a detected falling edge of the synchronized clock line, or after a start or stop condition.
- R10: A raised `mem_req_valid` holds, with a stable address, until accepted. Exactly one request is issued per byte sent, at the address of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 14 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |

## Verification
Two things can land in the same cycle: the address counter being bumped by a sequential fetch, and a memory request still waiting on a stalled ready. Both come from the same master acknowledge. The bench provokes this by dropping `mem_req_ready` at random, about one cycle in three, throughout long sequential reads, including one that crosses the 16383-to-0 wrap. Each returned byte is judged against the bench's own address tracking. A bench monitor also confirms that a stalled request keeps its address until it is accepted.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_TX,
    ST_TX_ACK
  } state_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sms_bus_sync.sv
module sms_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] cur;
  logic [NCH-1:0] prv;

  assign raw = {sda_in, scl_in};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chain  <= '1;
          prv[g] <= 1'b1;
        end else begin
          chain  <= {chain[STAGES-2:0], raw[g]};
          prv[g] <= chain[STAGES-1];
        end
      end
      assign cur[g] = chain[STAGES-1];
    end
  endgenerate

  // channel 0 = clock line, channel 1 = data line
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/sms_addr_ctr.sv
module sms_addr_ctr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          bump,
  output logic [AW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (bump) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sms_fetch.sv
module sms_fetch #(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else if (issue) begin
      mem_req_valid <= 1'b1;
      mem_req_addr  <= issue_addr;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (mem_rsp_valid) begin
      data_q <= mem_rsp_data;
    end
  end
endmodule

// File: rtl/serial_mem_rd_slave.sv
module serial_mem_rd_slave
  import sms_pkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data
);
  localparam int HI_W = ADDR_W - BYTE_W;
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] FULL_BYTE = 4'd8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  sms_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  state_t              state;
  logic [BYTE_W-1:0]   rx_sh;
  logic [BYTE_W-1:0]   tx_sh;
  logic [3:0]          bit_cnt;
  logic                rd_dir;
  logic                m_ack;
  logic [HI_W-1:0]     hi_q;
  logic [ADDR_W-1:0]   ctr;
  logic [BYTE_W-1:0]   fetched;

  logic byte_done, dev_match, fetch_go, ctr_load;

  assign byte_done = scl_fall && (bit_cnt == FULL_BYTE);
  assign dev_match = (rx_sh[7:4] == DEV_CODE);

  always_comb begin
    fetch_go = 1'b0;
    ctr_load = 1'b0;
    if (!start_det && !stop_det) begin
      if (state == ST_DEV && byte_done && dev_match && rx_sh[0]) fetch_go = 1'b1;
      if (state == ST_TX_ACK && scl_rise && !sda_s)              fetch_go = 1'b1;
      if (state == ST_ALO && byte_done)                          ctr_load = 1'b1;
    end
  end

  sms_addr_ctr #(.AW(ADDR_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .load(ctr_load),
    .load_val({hi_q, rx_sh}), .bump(fetch_go), .cnt(ctr)
  );

  sms_fetch #(.AW(ADDR_W), .DW(BYTE_W)) fetch_i (
    .clk(clk), .rst_n(rst_n), .issue(fetch_go), .issue_addr(ctr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .data_q(fetched)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      rx_sh         <= '0;
      tx_sh         <= '0;
      bit_cnt       <= '0;
      rd_dir        <= 1'b0;
      m_ack         <= 1'b0;
      hi_q          <= '0;
      sda_drive_low <= 1'b0;
    end else if (stop_det) begin
      state         <= ST_IDLE;
      sda_drive_low <= 1'b0;
    end else if (start_det) begin
      state         <= ST_DEV;
      bit_cnt       <= '0;
      sda_drive_low <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV, ST_AHI, ST_ALO: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_DEV) begin
              if (dev_match) begin
                rd_dir        <= rx_sh[0];
                sda_drive_low <= 1'b1;
                state         <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_AHI) begin
              hi_q          <= rx_sh[HI_W-1:0];
              sda_drive_low <= 1'b1;
              state         <= ST_AHI_ACK;
            end else begin
              sda_drive_low <= 1'b1;
              state         <= ST_ALO_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_dir) begin
              tx_sh         <= fetched;
              sda_drive_low <= ~fetched[7];
              state         <= ST_TX;
            end else begin
              sda_drive_low <= 1'b0;
              state         <= ST_AHI;
            end
          end
        end
        ST_AHI_ACK: begin
          if (scl_fall) begin
            sda_drive_low <= 1'b0;
            state         <= ST_ALO;
          end
        end
        ST_ALO_ACK: begin
          if (scl_fall) begin
            sda_drive_low <= 1'b0;
            state         <= ST_IDLE;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_drive_low <= 1'b0;
              state         <= ST_TX_ACK;
            end else begin
              tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_drive_low <= ~tx_sh[6];
              bit_cnt       <= bit_cnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (m_ack) begin
              tx_sh         <= fetched;
              sda_drive_low <= ~fetched[7];
              state         <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sms_checker.sv
module sms_checker
  import sms_pkg::*;
#(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_drive_low,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input state_t        state
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_sda_on_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> $past(scl_fall || start_det || stop_det));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_drive_low);

  p_start_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det |=> (state == ST_DEV));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_drive_low);
endmodule

bind serial_mem_rd_slave sms_checker #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_drive_low(sda_drive_low),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .state(state)
);

// File: tb/serial_mem_rd_slave_tb_top.sv
module serial_mem_rd_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_drive_low;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [13:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = '0;

  int errors = 0;
  int checks = 0;
  int r9_bad = 0;
  int r10_bad = 0;
  int req_cnt = 0;
  bit done = 1'b0;
  logic [13:0] exp_ctr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  serial_mem_rd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mem_val(input logic [13:0] a);
    return (a[7:0] * 8'd29) ^ {2'b10, a[13:8]};
  endfunction

  // memory model with random stalls; also watches the request hold rule
  logic prev_stall = 1'b0;
  logic [13:0] prev_addr = '0;
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_val(mem_req_addr);
    mem_req_ready <= ($urandom % 3) != 0;
    if (rst_n) begin
      if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) r10_bad <= r10_bad + 1;
      if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1;
    end
    prev_stall <= rst_n && mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_req_addr;
  end

  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_drive_low !== drv_prev) && scl_m) r9_bad = r9_bad + 1;
    drv_prev = sda_drive_low;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic v, output logic s);
    wq(); sda_m = v; wq(); scl_m = 1'b1; wq(); s = sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
  endtask

  task automatic read_run(input int n, input string tag);
    logic [7:0] b;
    logic s;
    for (int k = 0; k < n; k++) begin
      rd_byte(b);
      check(b == mem_val(exp_ctr), tag, b, mem_val(exp_ctr));
      exp_ctr = exp_ctr + 1'b1;
      bus_bit((k == n - 1) ? 1'b1 : 1'b0, s);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic rd);
    logic [2:0] sel;
    sel = 3'($urandom);
    return {4'b1010, sel, rd};
  endfunction

  task automatic addr_write(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    wr_byte(dev_byte(1'b0), a); check(a, "R3 dev write ack", a, 1);
    wr_byte(hi, a);             check(a, "R3 high ack", a, 1);
    wr_byte(lo, a);             check(a, "R3 low ack", a, 1);
    exp_ctr = {hi[5:0], lo};
  endtask

  task automatic random_read(input logic [13:0] addr, input int n);
    logic a;
    logic [1:0] junk;
    junk = 2'($urandom);
    bus_start();
    addr_write({junk, addr[13:8]}, addr[7:0]);
    bus_start();
    wr_byte(dev_byte(1'b1), a); check(a, "R5 dev read ack", a, 1);
    read_run(n, "R5 R6 random/sequential data");
    bus_stop();
  endtask

  task automatic current_read(input int n);
    logic a;
    bus_start();
    wr_byte(dev_byte(1'b1), a); check(a, "R4 dev read ack", a, 1);
    read_run(n, "R4 current-address data");
    bus_stop();
  endtask

  task automatic wrong_dev();
    logic a;
    logic [7:0] b;
    logic [3:0] code;
    code = 4'($urandom);
    if (code == 4'b1010) code = 4'b0110;
    bus_start();
    wr_byte({code, 3'($urandom), 1'($urandom)}, a);
    check(!a, "R2 foreign code not acked", a, 0);
    rd_byte(b);
    check(b == 8'hFF, "R2 no drive after foreign code", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    int req_base;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    check(sda_drive_low == 1'b0, "R1 reset sda released", sda_drive_low, 0);
    check(mem_req_valid == 1'b0, "R1 reset no request", mem_req_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: counter starts at 0
    current_read(1);
    // R5 R6: random read with sequential continuation
    random_read(14'h1234, 3);
    // R6: wrap at the top of the array, upper bits of high byte ignored (R3)
    bus_start(); addr_write(8'hFF, 8'hFE);
    bus_start(); wr_byte(dev_byte(1'b1), a); check(a, "R6 dev read ack", a, 1);
    read_run(4, "R6 wrap data");
    bus_stop();
    check(exp_ctr == 14'h0002, "R6 wrapped counter", exp_ctr, 2);
    // R4: current read continues after wrap
    current_read(2);
    // R2: foreign device code
    wrong_dev();
    current_read(1);
    // R8: stop after high byte leaves counter unchanged
    bus_start(); wr_byte(dev_byte(1'b0), a); check(a, "R8 dev ack", a, 1);
    wr_byte(8'h2A, a); check(a, "R8 high ack", a, 1);
    bus_stop();
    current_read(1);
    // R3: third written byte is not acknowledged
    bus_start(); addr_write(8'h03, 8'h10);
    wr_byte(8'h55, a); check(!a, "R3 third byte not acked", a, 0);
    bus_stop();
    current_read(1);
    // R7: after master NACK nothing is driven
    bus_start(); wr_byte(dev_byte(1'b1), a); check(a, "R7 dev ack", a, 1);
    read_run(1, "R7 data");
    rd_byte(b); check(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    bus_stop();
    // R10: one request per byte sent
    repeat (10) @(negedge clk);
    req_base = req_cnt;
    current_read(3);
    repeat (10) @(negedge clk);
    check(req_cnt - req_base == 3, "R10 one request per byte", req_cnt - req_base, 3);

    for (int it = 0; it < 24; it++) begin
      case ($urandom % 4)
        0: random_read(14'($urandom), 1 + int'($urandom % 3));
        1: current_read(1 + int'($urandom % 3));
        2: wrong_dev();
        default: begin
          bus_start();
          addr_write(8'($urandom), 8'($urandom));
          bus_stop();
          current_read(1);
        end
      endcase
    end

    check(r9_bad == 0, "R9 sda changed while clock high", r9_bad, 0);
    check(r10_bad == 0, "R10 stalled request not held", r10_bad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule